// File: doc/BRIEF.md
# Configurable Serial Character Receiver

This block recovers characters from an asynchronous serial line. An oversampling enable, sixteen per bit period and produced by a separate rate divider, paces all bit timing. The line is first passed through a two-stage synchronizer. A five-state controller then does the work:
- it hunts for a falling edge;
- it moves to the middle of the start bit and abandons the attempt if the line has gone high again;
- it times a full bit period between samples and takes each sample;
- it checks the stop bit or bits and then delivers the character.

The character width (five to eight bits), even parity and the number of stop bits are run-time inputs. They are latched when a start edge is seen, so they may change between frames. Each finished character appears on a parallel byte output with a single-cycle valid pulse. The framing and parity error flags are updated in the same cycle as the byte.

Top module: `uart_rx_core`

## Requirements
- R1: After reset the receiver is hunting, `rx_valid` is 0, `rx_data` is 0x00 and both error flags are 0.
- R2: The line idles high. A frame consists of, in time order, a low start bit, the data bits least significant first, an optional parity bit, and one or two high stop bits. The byte 0xCE sent with 8 data bits, no parity and one stop bit is delivered as 0xCE.
- R3: `cfg_len` codes 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. The received bits land right-justified in `rx_data`, and all unused upper bits read 0.
- R4: When `cfg_par_en` is 1, one parity bit follows the data. Even parity is expected, meaning the data bits plus the parity bit hold an even number of ones. `rx_par_err` is 1 exactly when this check fails. The parity bit never appears in `rx_data`.
- R5: A low level at any stop-bit sample sets `rx_frame_err` for that character. The data byte is still delivered with its valid pulse.
- R6: When `cfg_two_stop` is 1, two stop bits are sampled and both are checked. When it is 0, only one stop bit is sampled, and a new start bit may follow it immediately.
- R7: A low level on the line that has ended before the middle of the start bit (half a bit period after the edge) is abandoned. Nothing is delivered, and the receiver goes back to hunting.
- R8: `rx_valid` is high for exactly one clock cycle per frame. `rx_data` and both flags hold their values until the next delivery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| os_tick | input | 1 | Oversampling enable, 16 per bit period |
| rxd | input | 1 | Serial line, idle high |
| cfg_len | input | 2 | Data-length code (0..3 selects 5..8 bits) |
| cfg_par_en | input | 1 | Even parity bit present |
| cfg_two_stop | input | 1 | Two stop bits when 1 |
| rx_data | output | 8 | Last received character, right-justified |
| rx_valid | output | 1 | One-cycle delivery strobe |
| rx_frame_err | output | 1 | A stop sample was low in the last character |
| rx_par_err | output | 1 | Parity check failed in the last character |

## Verification
Characters are sent with asymmetric bit patterns such as 0xCE, so that any reversal of bit order or a one-position slip changes the delivered value. Each short length is sent with ones in the positions it must drop, which shows whether the upper bits are cleared. Frames with correct and with wrong parity, and with a low first or second stop bit, show that each error flag depends only on its own bit. Back-to-back frames and a short low glitch separate a proper return to hunting from a false-start abort.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [2:0] {
    ST_HUNT   = 3'd0,
    ST_CENTRE = 3'd1,
    ST_WAIT   = 3'd2,
    ST_SAMPLE = 3'd3,
    ST_STOP   = 3'd4
  } rx_state_t;

  typedef enum logic [1:0] {
    PH_DATA  = 2'd0,
    PH_PAR   = 2'd1,
    PH_STOP1 = 2'd2,
    PH_STOP2 = 2'd3
  } rx_phase_t;

  // data-length code to bit count: 0..3 -> 5..8
  function automatic logic [3:0] len_bits(input logic [1:0] code);
    return 4'd5 + {2'b00, code};
  endfunction

  // 1 when data plus parity bit hold an odd count of ones
  function automatic logic even_par_bad(input logic [7:0] data, input logic pbit);
    return (^data) ^ pbit;
  endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/rx_bit_timer.sv
module rx_bit_timer #(
  parameter int TICKS_PER_BIT = 16,
  localparam int CW = $clog2(TICKS_PER_BIT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          tick,
  output logic [CW-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n)    count <= '0;
    else if (clr)  count <= '0;
    else if (tick) count <= count + 1'b1;
  end
endmodule

// File: rtl/rx_capture.sv
module rx_capture #(
  parameter int MAX_BITS = 8,
  localparam int IW = $clog2(MAX_BITS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                rx_bit,
  input  logic                cap_data,
  input  logic [IW-1:0]       cap_idx,
  input  logic                cap_par,
  input  logic                cap_stop,
  output logic [MAX_BITS-1:0] data,
  output logic                par_bit,
  output logic                stop_low
);
  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      data     <= '0;
      par_bit  <= 1'b0;
      stop_low <= 1'b0;
    end else begin
      if (cap_data)            data[cap_idx] <= rx_bit;
      if (cap_par)             par_bit       <= rx_bit;
      if (cap_stop && !rx_bit) stop_low      <= 1'b1;
    end
  end
endmodule

// File: rtl/rx_fsm.sv
module rx_fsm
  import uart_rx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int MAX_BITS = 8,
  localparam int CW = $clog2(TICKS_PER_BIT),
  localparam int IW = $clog2(MAX_BITS),
  localparam int HALF = TICKS_PER_BIT / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          rx_bit,
  input  logic [CW-1:0] count,
  input  logic [1:0]    cfg_len,
  input  logic          cfg_par_en,
  input  logic          cfg_two_stop,
  output rx_state_t     state,
  output logic          timer_clr,
  output logic          ev_start,
  output logic          ev_false_start,
  output logic          ev_sample,
  output logic          ev_deliver,
  output logic          cap_data,
  output logic [IW-1:0] cap_idx,
  output logic          cap_par,
  output logic          cap_stop,
  output logic          par_en_q
);
  rx_state_t state_n;
  rx_phase_t phase, phase_n;
  logic [IW-1:0] idx_n;
  logic [3:0] nbits_q;
  logic two_stop_q;
  logic half_done, bit_done;

  assign half_done = tick && (count == CW'(HALF - 1));
  assign bit_done  = tick && (count == CW'(TICKS_PER_BIT - 1));

  always_comb begin
    state_n        = state;
    phase_n        = phase;
    idx_n          = cap_idx;
    timer_clr      = 1'b0;
    ev_start       = 1'b0;
    ev_false_start = 1'b0;
    ev_sample      = 1'b0;
    ev_deliver     = 1'b0;
    cap_data       = 1'b0;
    cap_par        = 1'b0;
    cap_stop       = 1'b0;
    case (state)
      ST_HUNT: begin
        timer_clr = 1'b1;
        if (tick && !rx_bit) begin
          ev_start = 1'b1;
          state_n  = ST_CENTRE;
        end
      end
      ST_CENTRE: begin
        if (half_done) begin
          timer_clr = 1'b1;
          if (rx_bit) begin
            ev_false_start = 1'b1;
            state_n        = ST_HUNT;
          end else begin
            state_n = ST_WAIT;
            phase_n = PH_DATA;
            idx_n   = '0;
          end
        end
      end
      ST_WAIT: begin
        if (bit_done) begin
          timer_clr = 1'b1;
          state_n   = ST_SAMPLE;
        end
      end
      ST_SAMPLE: begin
        ev_sample = 1'b1;
        timer_clr = 1'b1;
        state_n   = ST_WAIT;
        case (phase)
          PH_DATA: begin
            cap_data = 1'b1;
            if ({1'b0, cap_idx} == IW'(nbits_q - 4'd1)) phase_n = par_en_q ? PH_PAR : PH_STOP1;
            else idx_n = cap_idx + 1'b1;
          end
          PH_PAR: begin
            cap_par = 1'b1;
            phase_n = PH_STOP1;
          end
          PH_STOP1: begin
            cap_stop = 1'b1;
            if (two_stop_q) phase_n = PH_STOP2;
            else            state_n = ST_STOP;
          end
          default: begin
            cap_stop = 1'b1;
            state_n  = ST_STOP;
          end
        endcase
      end
      ST_STOP: begin
        ev_deliver = 1'b1;
        timer_clr  = 1'b1;
        state_n    = ST_HUNT;
      end
      default: state_n = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_HUNT;
      phase      <= PH_DATA;
      cap_idx    <= '0;
      nbits_q    <= 4'd8;
      par_en_q   <= 1'b0;
      two_stop_q <= 1'b0;
    end else begin
      state   <= state_n;
      phase   <= phase_n;
      cap_idx <= idx_n;
      if (ev_start) begin
        nbits_q    <= len_bits(cfg_len);
        par_en_q   <= cfg_par_en;
        two_stop_q <= cfg_two_stop;
      end
    end
  end
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import uart_rx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int MAX_BITS = 8,
  parameter int SYNC_STAGES = 2,
  localparam int CW = $clog2(TICKS_PER_BIT),
  localparam int IW = $clog2(MAX_BITS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                os_tick,
  input  logic                rxd,
  input  logic [1:0]          cfg_len,
  input  logic                cfg_par_en,
  input  logic                cfg_two_stop,
  output logic [MAX_BITS-1:0] rx_data,
  output logic                rx_valid,
  output logic                rx_frame_err,
  output logic                rx_par_err
);
  logic rx_s;
  logic [CW-1:0] tcount;
  rx_state_t state;
  logic timer_clr, ev_start, ev_false_start, ev_sample, ev_deliver;
  logic cap_data, cap_par, cap_stop, par_en_q;
  logic [IW-1:0] cap_idx;
  logic [MAX_BITS-1:0] cap_word;
  logic par_bit, stop_low;

  rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rxd), .dout(rx_s)
  );

  rx_bit_timer #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(timer_clr), .tick(os_tick), .count(tcount)
  );

  rx_fsm #(.TICKS_PER_BIT(TICKS_PER_BIT), .MAX_BITS(MAX_BITS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .tick(os_tick), .rx_bit(rx_s), .count(tcount),
    .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_two_stop(cfg_two_stop),
    .state(state), .timer_clr(timer_clr), .ev_start(ev_start),
    .ev_false_start(ev_false_start), .ev_sample(ev_sample), .ev_deliver(ev_deliver),
    .cap_data(cap_data), .cap_idx(cap_idx), .cap_par(cap_par), .cap_stop(cap_stop),
    .par_en_q(par_en_q)
  );

  rx_capture #(.MAX_BITS(MAX_BITS)) u_cap (
    .clk(clk), .rst_n(rst_n), .clear(ev_start), .rx_bit(rx_s),
    .cap_data(cap_data), .cap_idx(cap_idx), .cap_par(cap_par), .cap_stop(cap_stop),
    .data(cap_word), .par_bit(par_bit), .stop_low(stop_low)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_data      <= '0;
      rx_valid     <= 1'b0;
      rx_frame_err <= 1'b0;
      rx_par_err   <= 1'b0;
    end else begin
      rx_valid <= ev_deliver;
      if (ev_deliver) begin
        rx_data      <= cap_word;
        rx_frame_err <= stop_low;
        rx_par_err   <= par_en_q && even_par_bad(cap_word, par_bit);
      end
    end
  end
endmodule

// File: rtl/uart_rx_core_checks.sv
module uart_rx_core_checks
  import uart_rx_pkg::*;
#(
  parameter int MAX_BITS = 8
) (
  input logic                clk,
  input logic                rst_n,
  input rx_state_t           state,
  input logic                ev_false_start,
  input logic                ev_sample,
  input logic                rx_valid,
  input logic [MAX_BITS-1:0] rx_data,
  input logic                rx_frame_err,
  input logic                rx_par_err
);
  assert_valid_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  assert_valid_after_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(state) == ST_STOP);

  assert_hold_outputs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> ($stable(rx_data) && $stable(rx_frame_err) && $stable(rx_par_err)));

  assert_abort_to_hunt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_false_start |=> state == ST_HUNT);

  // R2: a sample is always followed by timing the next bit or by delivery
  assert_sample_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sample |=> (state == ST_WAIT || state == ST_STOP));

  assert_no_valid_when_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_false_start |=> !rx_valid);
endmodule

bind uart_rx_core uart_rx_core_checks #(.MAX_BITS(MAX_BITS)) u_checks (
  .clk(clk), .rst_n(rst_n), .state(state), .ev_false_start(ev_false_start),
  .ev_sample(ev_sample), .rx_valid(rx_valid), .rx_data(rx_data),
  .rx_frame_err(rx_frame_err), .rx_par_err(rx_par_err)
);

// File: tb/test_uart_rx_core.sv
`timescale 1ns/1ps
module test_uart_rx_core;
  localparam int BITCLK = 64; // 16 ticks, one tick every 4 clocks

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic os_tick = 1'b0;
  logic rxd = 1'b1;
  logic [1:0] cfg_len = 2'd3;
  logic cfg_par_en = 1'b0;
  logic cfg_two_stop = 1'b0;
  logic [7:0] rx_data;
  logic rx_valid, rx_frame_err, rx_par_err;

  int n_checks = 0;
  int n_fail = 0;
  int n_valid = 0;
  int n_wide = 0;
  logic prev_valid = 1'b0;
  logic [7:0] last_data = 8'h00;
  logic last_ferr = 1'b0, last_perr = 1'b0;
  logic [1:0] tdiv = 2'd0;
  bit done = 1'b0;

  uart_rx_core i_uart_rx_core (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
    .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_two_stop(cfg_two_stop),
    .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_frame_err(rx_frame_err), .rx_par_err(rx_par_err)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    tdiv    <= tdiv + 2'd1;
    os_tick <= (tdiv == 2'd3);
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_valid) begin
        n_valid   <= n_valid + 1;
        last_data <= rx_data;
        last_ferr <= rx_frame_err;
        last_perr <= rx_par_err;
        if (prev_valid) n_wide <= n_wide + 1;
      end
      prev_valid <= rx_valid;
    end else prev_valid <= 1'b0;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic line_bits(input logic b, input int bits);
    @(negedge clk) rxd = b;
    repeat (bits * BITCLK - 1) @(negedge clk);
  endtask

  // send one frame; bad_par flips parity, s1/s2 are the stop levels
  task automatic send(input logic [7:0] d, input int nb, input logic par,
                      input logic bad_par, input logic s1, input logic two, input logic s2);
    logic [7:0] m;
    m = d & 8'((1 << nb) - 1);
    line_bits(1'b0, 1);
    for (int i = 0; i < nb; i++) line_bits(d[i], 1);
    if (par) line_bits((^m) ^ bad_par, 1);
    line_bits(s1, 1);
    if (two) line_bits(s2, 1);
  endtask

  task automatic do_reset;
    rxd = 1'b1;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (BITCLK) @(negedge clk);
  endtask

  task automatic t_reset;
    do_reset();
    check("R1 valid", rx_valid, 0);
    check("R1 data", rx_data, 8'h00);
    check("R1 ferr", rx_frame_err, 0);
    check("R1 perr", rx_par_err, 0);
  endtask

  task automatic t_basic;
    int c0;
    c0 = n_valid;
    cfg_len = 2'd3; cfg_par_en = 0; cfg_two_stop = 0;
    send(8'hCE, 8, 0, 0, 1, 0, 1);
    check("R2 count", n_valid - c0, 1);
    check("R2 data CE", last_data, 8'hCE);
    check("R2 ferr", last_ferr, 0);
    check("R2 perr", last_perr, 0);
    send(8'h35, 8, 0, 0, 1, 0, 1);
    check("R2 data 35", last_data, 8'h35);
  endtask

  task automatic t_lengths;
    for (int c = 0; c < 3; c++) begin
      cfg_len = 2'(c);
      send(8'hFF ^ 8'h02, 5 + c, 0, 0, 1, 0, 1);
      check("R3 short length", last_data, 8'hFD & 8'((1 << (5 + c)) - 1));
    end
    cfg_len = 2'd3;
  endtask

  task automatic t_parity;
    cfg_par_en = 1;
    send(8'hA7, 8, 1, 0, 1, 0, 1);
    check("R4 good par perr", last_perr, 0);
    check("R4 good par data", last_data, 8'hA7);
    send(8'hA7, 8, 1, 1, 1, 0, 1);
    check("R4 bad par perr", last_perr, 1);
    cfg_len = 2'd1;
    send(8'h2C, 6, 1, 0, 1, 0, 1);
    check("R4 6-bit par data", last_data, 8'h2C);
    check("R4 6-bit par perr", last_perr, 0);
    cfg_len = 2'd3; cfg_par_en = 0;
  endtask

  task automatic t_frame_err;
    int c0;
    c0 = n_valid;
    send(8'h5A, 8, 0, 0, 0, 0, 1);
    check("R5 delivered", n_valid - c0, 1);
    check("R5 ferr", last_ferr, 1);
    check("R5 data", last_data, 8'h5A);
    do_reset();
  endtask

  task automatic t_stops;
    int c0;
    cfg_two_stop = 1;
    send(8'h81, 8, 0, 0, 1, 1, 1);
    check("R6 two stop ok ferr", last_ferr, 0);
    send(8'h81, 8, 0, 0, 1, 1, 0);
    check("R6 second stop low ferr", last_ferr, 1);
    do_reset();
    cfg_two_stop = 0;
    c0 = n_valid;
    send(8'h3C, 8, 0, 0, 1, 0, 1);
    send(8'hC3, 8, 0, 0, 1, 0, 1);
    check("R6 back to back count", n_valid - c0, 2);
    check("R6 back to back data", last_data, 8'hC3);
    check("R6 back to back ferr", last_ferr, 0);
  endtask

  task automatic t_glitch;
    int c0;
    c0 = n_valid;
    @(negedge clk) rxd = 1'b0;
    repeat (12) @(negedge clk);
    rxd = 1'b1;
    repeat (4 * BITCLK) @(negedge clk);
    check("R7 glitch no delivery", n_valid - c0, 0);
    send(8'h96, 8, 0, 0, 1, 0, 1);
    check("R7 frame after glitch", last_data, 8'h96);
  endtask

  task automatic t_hold;
    repeat (3 * BITCLK) @(negedge clk);
    check("R8 data held", rx_data, 8'h96);
    check("R8 valid low idle", rx_valid, 0);
    check("R8 single-cycle pulses", n_wide, 0);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_lengths();
    t_parity();
    t_frame_err();
    t_stops();
    t_glitch();
    t_hold();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule